// File: doc/BRIEF.md
# I2C DMA Transfer Command Sequencer

This block sits between a DMA-fed byte FIFO and a byte-level I2C engine, which may run as a master or as a slave. Software sets a mode register, a transfer length and a one-byte control word. The block then produces every per-byte bus command of the transfer by itself. Software never pushes dummy read entries into the FIFO.

In write direction the block turns each FIFO byte into a data command. In read direction it issues the programmed number of read commands and leaves the FIFO alone. After the final data byte it appends the requested STOP or RESTART command. A `busy` level marks a running transfer, and a one-cycle `done` pulse marks its end. Master and slave operation share the same command stream.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Register address 0 is the mode register. Bit 0 is the enable and bits [2:1] are the mode field; the sequencer is armed only when the enable is 1 and the mode field is 2'b01. A control-word write while the sequencer is not armed starts nothing: no command, no busy, no done.
- R2: Register address 2 is the control word. Bit 0 selects read (1) or write (0), bit 1 requests RESTART and bit 2 requests STOP. Bits [7:3] have no effect. Writing it while armed and idle starts a transfer.
- R3: Register address 1 holds the 8-bit transfer length, which is the number of data commands issued.
- R4: In write direction each data command has op WRITE (code 0) and carries the next FIFO byte, in FIFO order. A FIFO byte is popped only in the cycle its command is accepted.
- R5: In write direction, while the FIFO is empty, the block raises no command and waits without skipping any byte.
- R6: In read direction the block issues exactly length commands with op READ (code 1) and never asserts `tx_ready`.
- R7: After the last data command the block issues STOP (code 3) if the STOP bit is set, otherwise RESTART (code 2) if the RESTART bit is set, otherwise nothing. STOP wins when both bits are set.
- R8: `busy` rises the cycle after the starting control write and falls once the final command is accepted. `done` is high for exactly one cycle, in that same cycle, and never together with `busy`.
- R9: A length of zero issues no command, keeps `busy` low and pulses `done` in the cycle after the control write.
- R10: Register writes made while `busy` is high change no register: neither the mode, the length nor the control word.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the offered op and data hold steady until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 length, 2 control) |
| reg_wdata | input | 8 | Register write data |
| tx_data | input | 8 | Byte at the head of the transmit FIFO |
| tx_valid | input | 1 | FIFO holds a byte |
| tx_ready | output | 1 | FIFO pop, the head byte is consumed |
| cmd_valid | output | 1 | Command offered to the I2C engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | Command op: 0 WRITE, 1 READ, 2 RESTART, 3 STOP |
| cmd_data | output | 8 | Byte for WRITE commands, zero otherwise |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The command stream is exercised with write transfers from a preloaded FIFO and from a FIFO that starts empty. This shows whether the block stalls or skips bytes. Read transfers run with bytes parked in the FIFO, which shows whether the FIFO is touched at all. All four combinations of the end-condition bits are used, together with reserved bits, so that STOP priority and a missing tail command can be told apart. Zero length, a disarmed or wrongly moded sequencer, a toggling engine ready, and register writes during a transfer separate the start, handshake and write-lockout rules from the normal path.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_LEN  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] SEQ_MODE  = 2'b01;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_READ    = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic stop;
        logic restart;
        logic read;
    } xfer_ctrl_t;

    function automatic xfer_ctrl_t decode_ctrl(input logic [7:0] w);
        xfer_ctrl_t c;
        c.read    = w[0];
        c.restart = w[1];
        c.stop    = w[2];
        return c;
    endfunction

    function automatic logic needs_tail(input xfer_ctrl_t c);
        return c.stop | c.restart;
    endfunction

    function automatic cmd_op_e tail_op(input xfer_ctrl_t c);
        return c.stop ? OP_STOP : OP_RESTART;
    endfunction

endpackage

// File: rtl/i2c_cmd_seq_regs.sv
module i2c_cmd_seq_regs
    import i2c_cmd_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             busy,
    output logic [LEN_W-1:0] len_o,
    output xfer_ctrl_t       ctrl_o,
    output logic             start_o
);
    logic       en_q;
    logic [1:0] mode_q;
    logic       wr_ok;

    assign wr_ok   = we && !busy;
    assign start_o = wr_ok && (addr == ADDR_CTRL) && en_q && (mode_q == SEQ_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= 2'b00;
            len_o  <= '0;
            ctrl_o <= '0;
        end else if (wr_ok) begin
            case (addr)
                ADDR_MODE: begin
                    en_q   <= wdata[0];
                    mode_q <= wdata[2:1];
                end
                ADDR_LEN:  len_o  <= LEN_W'(wdata);
                ADDR_CTRL: ctrl_o <= decode_ctrl(wdata);
                default: ;
            endcase
        end
    end

    assert_locked_len_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(len_o) || !$past(busy));

endmodule

// File: rtl/i2c_cmd_seq_cnt.sv
module i2c_cmd_seq_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    output logic             last_o,
    output logic             zero_len_o
);
    logic [LEN_W-1:0] remain_q;

    assign last_o     = (remain_q == LEN_W'(1));
    assign zero_len_o = (len == '0);

    always_ff @(posedge clk) begin
        if (rst)       remain_q <= '0;
        else if (load) remain_q <= len;
        else if (dec)  remain_q <= remain_q - LEN_W'(1);
    end

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        dec |-> remain_q != '0);

endmodule

// File: rtl/i2c_cmd_seq_fsm.sv
module i2c_cmd_seq_fsm
    import i2c_cmd_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              zero_len,
    input  logic              last,
    input  xfer_ctrl_t        ctrl,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output cmd_op_e           cmd_op,
    output logic [DATA_W-1:0] cmd_data,
    output logic              beat_o,
    output logic              busy,
    output logic              done
);
    seq_state_e state_q;
    logic       tail_fire;

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_WRITE;
        cmd_data  = '0;
        case (state_q)
            ST_DATA: begin
                cmd_op    = ctrl.read ? OP_READ : OP_WRITE;
                cmd_valid = ctrl.read ? 1'b1 : tx_valid;
                cmd_data  = ctrl.read ? '0 : tx_data;
            end
            ST_TAIL: begin
                cmd_op    = tail_op(ctrl);
                cmd_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign beat_o    = (state_q == ST_DATA) && cmd_valid && cmd_ready;
    assign tx_ready  = (state_q == ST_DATA) && !ctrl.read && cmd_ready;
    assign tail_fire = (state_q == ST_TAIL) && cmd_ready;
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    if (zero_len) done    <= 1'b1;
                    else          state_q <= ST_DATA;
                end
                ST_DATA: if (beat_o && last) begin
                    if (needs_tail(ctrl)) state_q <= ST_TAIL;
                    else begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                ST_TAIL: if (tail_fire) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_no_empty_write_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_WRITE) |-> tx_valid);
    assert_read_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_READ) |-> !tx_ready);
    assert_tail_op_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL) |-> (cmd_op == OP_STOP || cmd_op == OP_RESTART));
    assert_hold_op_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && cmd_op != OP_WRITE) |=> cmd_valid && $stable(cmd_op));

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_cmd_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done
);
    logic [LEN_W-1:0] len;
    xfer_ctrl_t       ctrl;
    logic             start, last, zero_len, beat;
    cmd_op_e          op;

    i2c_cmd_seq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .len_o(len), .ctrl_o(ctrl), .start_o(start)
    );

    i2c_cmd_seq_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst(rst), .load(start), .len(len), .dec(beat),
        .last_o(last), .zero_len_o(zero_len)
    );

    i2c_cmd_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .zero_len(zero_len), .last(last),
        .ctrl(ctrl), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(op),
        .cmd_data(cmd_data), .beat_o(beat), .busy(busy), .done(done)
    );

    assign cmd_op = op;

    assert_pop_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && tx_valid) |-> (cmd_valid && cmd_ready && cmd_op == 2'd0));

endmodule

// File: tb/i2c_cmd_seq_tb_top.sv
module i2c_cmd_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] tx_data;
    logic       tx_valid, tx_ready, cmd_valid, busy, done;
    logic       cmd_ready = 1'b1;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data;

    always #2.5 clk = ~clk;

    i2c_cmd_seq dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .busy(busy), .done(done)
    );

    int checks = 0, fails = 0;

    // transmit FIFO model
    logic [7:0] fmem [0:63];
    int wr_ptr = 0, rd_ptr = 0;
    assign tx_valid = (rd_ptr < wr_ptr);
    assign tx_data  = fmem[rd_ptr[5:0]];
    always @(posedge clk) if (tx_valid && tx_ready) rd_ptr <= rd_ptr + 1;

    // engine ready pattern
    logic bp = 1'b0;
    logic [2:0] bp_cnt = 3'd0;
    always @(posedge clk) begin
        bp_cnt <= bp_cnt + 3'd1;
        cmd_ready <= bp ? (bp_cnt[0] ^ bp_cnt[2]) : 1'b1;
    end

    // command and status monitor, sampled at negedge
    logic [1:0] op_log [0:63];
    logic [7:0] dat_log [0:63];
    int ncmd = 0, ndone = 0, hold_err = 0;
    logic       prev_stall = 1'b0;
    logic [1:0] prev_op = 2'd0;
    logic [7:0] prev_dat = 8'd0;
    always @(negedge clk) if (!rst) begin
        if (prev_stall && (!cmd_valid || cmd_op != prev_op || cmd_data != prev_dat))
            hold_err++;
        prev_stall = cmd_valid && !cmd_ready;
        prev_op    = cmd_op;
        prev_dat   = cmd_data;
        if (cmd_valid && cmd_ready) begin
            op_log[ncmd[5:0]]  = cmd_op;
            dat_log[ncmd[5:0]] = cmd_data;
            ncmd++;
        end
        if (done) ndone++;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        fmem[wr_ptr[5:0]] = d;
        wr_ptr++;
    endtask

    task automatic clear_log();
        ncmd = 0; ndone = 0; hold_err = 0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (ndone == 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(req, ndone, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R8 reset busy", int'(busy), 0);
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset cmd_valid", int'(cmd_valid), 0);
        chk("R4 reset tx_ready", int'(tx_ready), 0);
    endtask

    task automatic test_disarmed();
        clear_log();
        reg_write(2'd0, 8'h02);           // mode ok, enable off
        reg_write(2'd1, 8'd3);
        reg_write(2'd2, 8'h01);
        repeat (8) @(negedge clk);
        reg_write(2'd0, 8'h05);           // enable on, wrong mode field
        reg_write(2'd2, 8'h01);
        repeat (8) @(negedge clk);
        chk("R1 disarmed commands", ncmd, 0);
        chk("R1 disarmed done", ndone, 0);
        chk("R1 disarmed busy", int'(busy), 0);
    endtask

    task automatic test_write_stop();
        clear_log();
        reg_write(2'd0, 8'h03);
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
        reg_write(2'd1, 8'd4);
        reg_write(2'd2, 8'h04);
        wait_done("R8 write done");
        chk("R3 write count", ncmd, 5);
        for (int i = 0; i < 4; i++) begin
            chk("R4 write op", int'(op_log[i]), 0);
            chk("R4 write data", int'(dat_log[i]), 'hA0 + i);
        end
        chk("R7 stop tail", int'(op_log[4]), 3);
        chk("R4 fifo consumed", rd_ptr, wr_ptr);
    endtask

    task automatic test_read_restart();
        int rd0;
        clear_log();
        push(8'h11); push(8'h22);
        rd0 = rd_ptr;
        reg_write(2'd1, 8'd3);
        reg_write(2'd2, 8'h03);
        wait_done("R8 read done");
        chk("R6 read count", ncmd, 4);
        for (int i = 0; i < 3; i++) chk("R6 read op", int'(op_log[i]), 1);
        chk("R7 restart tail", int'(op_log[3]), 2);
        chk("R6 fifo untouched", rd_ptr, rd0);
    endtask

    task automatic test_both_bits();
        clear_log();
        reg_write(2'd1, 8'd2);
        reg_write(2'd2, 8'h07);
        wait_done("R7 both done");
        chk("R7 both count", ncmd, 3);
        chk("R7 stop priority", int'(op_log[2]), 3);
        rd_ptr = wr_ptr;                  // drop parked bytes
    endtask

    task automatic test_no_tail();
        clear_log();
        push(8'h5C);
        reg_write(2'd1, 8'd1);
        reg_write(2'd2, 8'hF8);           // write, reserved bits set
        wait_done("R2 reserved done");
        chk("R2 reserved count", ncmd, 1);
        chk("R2 reserved op", int'(op_log[0]), 0);
        chk("R4 single data", int'(dat_log[0]), 'h5C);
    endtask

    task automatic test_zero_len();
        clear_log();
        reg_write(2'd1, 8'd0);
        reg_write(2'd2, 8'h05);
        @(negedge clk);
        chk("R9 zero done", int'(done), 1);
        chk("R9 zero busy", int'(busy), 0);
        @(negedge clk);
        chk("R9 zero done once", int'(done), 0);
        repeat (4) @(negedge clk);
        chk("R9 zero commands", ncmd, 0);
    endtask

    task automatic test_timing();
        clear_log();
        reg_write(2'd1, 8'd1);
        reg_write(2'd2, 8'h01);
        @(negedge clk);
        chk("R8 busy rises", int'(busy), 1);
        chk("R8 read offered", int'(cmd_valid), 1);
        @(negedge clk);
        chk("R8 busy falls", int'(busy), 0);
        chk("R8 done pulse", int'(done), 1);
        @(negedge clk);
        chk("R8 done ends", int'(done), 0);
    endtask

    task automatic test_stall();
        clear_log();
        reg_write(2'd1, 8'd3);
        reg_write(2'd2, 8'h00);
        repeat (5) @(negedge clk);
        chk("R5 stall no valid", int'(cmd_valid), 0);
        chk("R5 stall no cmds", ncmd, 0);
        chk("R5 stall busy", int'(busy), 1);
        push(8'h31); push(8'h32); push(8'h33);
        wait_done("R5 stall done");
        chk("R5 stall count", ncmd, 3);
        for (int i = 0; i < 3; i++) chk("R5 stall order", int'(dat_log[i]), 'h31 + i);
    endtask

    task automatic test_busy_lock();
        clear_log();
        bp = 1'b1;
        reg_write(2'd1, 8'd5);
        reg_write(2'd2, 8'h01);
        reg_write(2'd1, 8'd1);            // ignored while busy
        reg_write(2'd0, 8'h00);           // ignored while busy
        reg_write(2'd2, 8'h04);           // ignored while busy
        wait_done("R10 first done");
        chk("R10 first count", ncmd, 5);
        chk("R11 held under backpressure", hold_err, 0);
        clear_log();
        reg_write(2'd2, 8'h01);
        wait_done("R10 second done");
        chk("R10 length kept", ncmd, 5);
        chk("R11 held again", hold_err, 0);
        bp = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_disarmed();
        test_write_stop();
        test_read_restart();
        test_both_bits();
        test_no_tail();
        test_zero_len();
        test_timing();
        test_stall();
        test_busy_lock();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule